// File: doc/BRIEF.md
# Interleaved Counter Bank Time Code Combiner

This block turns a bank of K parallel cycle counters into a single fine-grained time code. Every counter runs on one shared reference clock, and each is gated by its own copy of a measurement enable that has passed through a different point of an external delay line. Tap 0 drives a full-width coarse counter held in Gray code. Every other tap drives a two-bit counter. Because the whole delay line spans one reference period, each of those counters can only be one count behind, level with, or one count ahead of the coarse counter.

When the most delayed tap goes low, the block freezes the bank and records the coarse value in binary. It then visits one tap per clock cycle. For each tap it rebuilds the full count from the coarse value and the two-bit residue, and adds it to a running total. The finished total is the measured interval in units of one K-th of a reference period. It is issued with a one-cycle strobe and held until the next result. The bank then clears itself, so the next measurement starts from zero.

The tap enables arrive already sampled in the reference clock domain. The result side is a plain strobe: it cannot be stalled, there is no ready input, and a consumer must take the code in the strobe cycle or read the held value later.

Top module: `tdc_combiner`

## Requirements
- R1: While the tap 0 enable is high, its coarse counter adds one per reference clock, and it holds its value while that enable is low. Its count enters the result unchanged.
- R2: For every tap other than tap 0, the full count is rebuilt from its two-bit counter `r` and the low two bits `c` of the binary coarse count. The rebuilt count is the coarse count plus +1 when (r − c) mod 4 = 1, plus 0 when it is 0, and plus −1 when it is 3.
- R3: `code_o` equals the sum of the rebuilt counts of all NTAP taps, modulo 2^OW, where OW = CW + log2(NTAP).
- R4: Capture happens at the first clock edge that samples tap NTAP−1 low after sampling it high. `code_valid` is high in exactly one cycle, the one that begins NTAP+2 edges after the capture edge.
- R5: Tap enables that are high between the capture edge and the `code_valid` cycle change neither the counters nor the result, and they do not start a new measurement.
- R6: All counters clear on the edge that raises `code_valid`, so a measurement started right after a result counts from zero.
- R7: A residue difference of 2 sets `range_err`, and that tap then contributes the coarse count. `range_err` stays set until reset.
- R8: A synchronous active-low reset clears `code_o`, `code_valid`, `range_err` and every counter.
- R9: `code_o` changes only when a new result is issued, and it holds that result until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock shared by all counters |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_en | input | NTAP | Delayed enable copies, bit 0 least delayed, bit NTAP−1 most delayed |
| code_o | output | OW | Summed time code, held between results |
| code_valid | output | 1 | One-cycle strobe marking a new `code_o` |
| range_err | output | 1 | Sticky flag for a residue out of the ±1 range |

## Verification
Each result is due NTAP+2 edges after the capture edge. The capture edge is the first edge that samples the last tap low, so the bench knows the exact capture edge from the step at which it drove that tap low. From that point it samples `code_valid` on every falling edge and records the index at which the strobe appears. It expects exactly one strobe, on falling edge NTAP+3, and only then compares `code_o` with the sum of the high cycles it counted per tap. One falling edge later it confirms that `code_o` still holds that value, and it checks the held code again as the next measurement starts. Tap enables driven between capture and the strobe fall within the frozen window, so their effect, if any, would show up in that same result.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  // Offset class of a two-bit residue relative to the coarse low bits.
  typedef enum logic [1:0] {
    OFS_ZERO  = 2'd0,
    OFS_PLUS  = 2'd1,
    OFS_BAD   = 2'd2,
    OFS_MINUS = 2'd3
  } ofs_e;

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/tdc_gray_ctr.sv
module tdc_gray_ctr
  import tdc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] g_q;
  logic [CW-1:0] b_nx;

  // Step in binary, store in Gray so only one bit moves per count.
  assign b_nx = CW'(gray2bin(32'(g_q))) + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) g_q <= '0;
    else if (en)       g_q <= CW'(bin2gray(32'(b_nx)));
  end

  assign gray_o = g_q;
endmodule

// File: rtl/tdc_residue_bank.sv
module tdc_residue_bank #(
  parameter int NRES = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NRES-1:0]   en,
  output logic [2*NRES-1:0] res_o
);
  for (genvar j = 0; j < NRES; j++) begin : g_res
    logic [1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) c_q <= 2'b00;
      else if (en[j])    c_q <= c_q + 2'b01;
    end
    assign res_o[2*j +: 2] = c_q;
  end
endmodule

// File: rtl/tdc_seq_sum.sv
module tdc_seq_sum
  import tdc_pkg::*;
#(
  parameter int NTAP = 1024,
  parameter int CW   = 4,
  parameter int OW   = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  last_en,
  input  logic [CW-1:0]         coarse_g,
  input  logic [2*(NTAP-1)-1:0] res_i,
  output logic                  busy_o,
  output logic                  start_o,
  output logic                  clr_o,
  output logic [OW-1:0]         code_o,
  output logic                  code_valid,
  output logic                  range_err
);
  localparam int IW = (NTAP > 1) ? $clog2(NTAP) : 1;

  logic          last_q, busy_q, scan_q, tv_q, fin_q, vld_q, err_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] base_q;
  logic [OW-1:0] term_q, acc_q, code_q;

  logic [2*NTAP-1:0] slots;
  logic [1:0]        rsel;
  ofs_e              ofs;
  logic [OW-1:0]     base_ext, term_d;
  logic              start;

  // Capture on the falling edge of the most delayed tap, only when idle.
  assign start = !busy_q && last_q && !last_en;

  // Slot 0 is the reference tap: its residue equals the coarse low bits.
  assign slots    = {res_i, base_q[1:0]};
  assign rsel     = slots[{idx_q, 1'b0} +: 2];
  assign ofs      = ofs_e'(rsel - base_q[1:0]);
  assign base_ext = OW'(base_q);

  always_comb begin
    unique case (ofs)
      OFS_PLUS:  term_d = base_ext + OW'(1);
      OFS_MINUS: term_d = base_ext - OW'(1);
      default:   term_d = base_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      busy_q <= 1'b0;
      scan_q <= 1'b0;
      tv_q   <= 1'b0;
      fin_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      term_q <= '0;
      acc_q  <= '0;
      code_q <= '0;
    end else begin
      last_q <= last_en;
      vld_q  <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        scan_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= '0;
        base_q <= CW'(gray2bin(32'(coarse_g)));
      end
      // Stage 1: select one tap and rebuild its full count.
      if (scan_q) begin
        term_q <= term_d;
        if (ofs == OFS_BAD) err_q <= 1'b1;
        if (idx_q == IW'(NTAP-1)) scan_q <= 1'b0;
        else                      idx_q  <= idx_q + 1'b1;
      end
      // Stage 2: single shared adder.
      tv_q <= scan_q;
      if (tv_q) acc_q <= acc_q + term_q;
      fin_q <= tv_q && !scan_q;
      if (fin_q) begin
        vld_q  <= 1'b1;
        code_q <= acc_q;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign start_o    = start;
  assign clr_o      = fin_q;
  assign code_o     = code_q;
  assign code_valid = vld_q;
  assign range_err  = err_q;
endmodule

// File: rtl/tdc_combiner.sv
module tdc_combiner
  import tdc_pkg::*;
#(
  parameter  int NTAP = 1024,
  parameter  int CW   = 4,
  localparam int OW   = CW + $clog2(NTAP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTAP-1:0] tap_en,
  output logic [OW-1:0]   code_o,
  output logic            code_valid,
  output logic            range_err
);
  logic                  busy_w, start_w, clr_w;
  logic [CW-1:0]         coarse_g;
  logic [2*(NTAP-1)-1:0] res_w;
  logic [NTAP-2:0]       res_en;

  // Freeze the whole bank from capture until the result is issued.
  assign res_en = tap_en[NTAP-1:1] & {(NTAP-1){~busy_w}};

  tdc_gray_ctr #(.CW(CW)) u_coarse (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_w),
    .en     (tap_en[0] & ~busy_w),
    .gray_o (coarse_g)
  );

  tdc_residue_bank #(.NRES(NTAP-1)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_w),
    .en    (res_en),
    .res_o (res_w)
  );

  tdc_seq_sum #(.NTAP(NTAP), .CW(CW), .OW(OW)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_en    (tap_en[NTAP-1]),
    .coarse_g   (coarse_g),
    .res_i      (res_w),
    .busy_o     (busy_w),
    .start_o    (start_w),
    .clr_o      (clr_w),
    .code_o     (code_o),
    .code_valid (code_valid),
    .range_err  (range_err)
  );
endmodule

// File: rtl/tdc_combiner_chk.sv
module tdc_combiner_chk #(
  parameter int NTAP = 1024,
  parameter int CW   = 4,
  parameter int OW   = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          code_valid,
  input logic [OW-1:0] code_o,
  input logic          range_err,
  input logic          busy,
  input logic          start,
  input logic          clr,
  input logic [CW-1:0] coarse_g
);
  localparam int LW  = $clog2(NTAP + 4) + 1;
  localparam int LAT = NTAP + 3;

  logic [LW-1:0] lat_q;

  // Edges elapsed since capture, counted independently of the sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n)           lat_q <= '0;
    else if (start)       lat_q <= LW'(1);
    else if (code_valid)  lat_q <= '0;
    else if (lat_q != '0) lat_q <= lat_q + 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> lat_q == LW'(LAT));

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid);

  p_hold_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(code_o)) |-> code_valid);

  p_sticky_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> $stable(coarse_g));

  p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && !$stable(coarse_g))
      |-> $countones(coarse_g ^ $past(coarse_g)) == 1);
endmodule

bind tdc_combiner tdc_combiner_chk #(.NTAP(NTAP), .CW(CW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_valid (code_valid),
  .code_o     (code_o),
  .range_err  (range_err),
  .busy       (busy_w),
  .start      (start_w),
  .clr        (clr_w),
  .coarse_g   (coarse_g)
);

// File: tb/tdc_combiner_test.sv
module tdc_combiner_test;
  localparam int NTAP = 16;
  localparam int CW   = 4;
  localparam int OW   = CW + $clog2(NTAP);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NTAP-1:0] tap_en = '0;
  logic [OW-1:0]   code_o;
  logic            code_valid, range_err;

  int total = 0;
  int bad   = 0;
  int ds[NTAP];
  int de[NTAP];
  int cnt_ref[NTAP];
  logic [OW-1:0] last_code = '0;

  always #10 clk = ~clk;

  tdc_combiner #(.NTAP(NTAP), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tap_en(tap_en),
    .code_o(code_o), .code_valid(code_valid), .range_err(range_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_skews();
    for (int i = 0; i < NTAP; i++) begin ds[i] = 0; de[i] = 0; end
  endtask

  // Tap i is high for steps ds[i] .. len+de[i]-1; the last tap must fall last.
  task automatic measure(input string req, input int len, input bit noise);
    int tend = 0;
    int seen = -1;
    int nv = 0;
    logic [OW-1:0] exp = '0;
    check({req, " R9 held code before run"}, 32'(code_o), 32'(last_code));
    for (int i = 0; i < NTAP; i++) begin
      cnt_ref[i] = 0;
      if (len + de[i] > tend) tend = len + de[i];
    end
    for (int t = 0; t <= tend; t++) begin
      @(negedge clk);
      for (int i = 0; i < NTAP; i++) begin
        tap_en[i] = (t >= ds[i]) && (t < len + de[i]);
        cnt_ref[i] += ((t >= ds[i]) && (t < len + de[i])) ? 1 : 0;
      end
    end
    for (int j = 1; j <= NTAP + 4; j++) begin
      @(negedge clk);
      if (code_valid) begin
        nv++;
        if (seen < 0) seen = j;
      end
      if (noise) tap_en = (j >= 2 && j <= 6) ? '1 : '0;
      if (j == NTAP + 3) begin
        for (int i = 0; i < NTAP; i++)
          exp += (cnt_ref[i] - cnt_ref[0] == 2) ? OW'(cnt_ref[0]) : OW'(cnt_ref[i]);
        check({req, " R3 code"}, 32'(code_o), 32'(exp));
      end
    end
    tap_en = '0;
    check({req, " R4 strobe edge"}, 32'(seen), 32'(NTAP + 3));
    check({req, " R4 strobe width"}, 32'(nv), 32'd1);
    check({req, " R9 code holds"}, 32'(code_o), 32'(exp));
    last_code = exp;
  endtask

  task automatic t_reset();
    check("R8 reset code", 32'(code_o), 32'd0);
    check("R8 reset valid", 32'(code_valid), 32'd0);
    check("R8 reset err", 32'(range_err), 32'd0);
  endtask

  task automatic t_aligned();  // R1 R3: all taps equal
    clear_skews();
    measure("R1 aligned", 5, 1'b0);
    check("R1 aligned sum", 32'(last_code), 32'(NTAP * 5));
  endtask

  task automatic t_skew();  // R2: offsets -1, 0, +1
    clear_skews();
    for (int i = 0; i < NTAP; i++) begin
      ds[i] = i % 2;
      de[i] = (i >= NTAP / 2) ? 1 : 0;
    end
    de[NTAP-1] = 1;
    measure("R2 skew", 9, 1'b0);
    check("R7 no err on skew", 32'(range_err), 32'd0);
  endtask

  task automatic t_wrap();  // R2: residues wrapping past the coarse low bits
    clear_skews();
    for (int i = 0; i < NTAP; i++) begin
      ds[i] = (i % 3 == 1) ? 1 : 0;
      de[i] = (i % 3 == 2) ? 1 : 0;
    end
    de[NTAP-1] = 1;
    measure("R2 wrap len4", 4, 1'b0);
    measure("R2 wrap len13", 13, 1'b0);
  endtask

  task automatic t_noise();  // R5: enables during the frozen window
    clear_skews();
    for (int i = 0; i < NTAP; i++) ds[i] = i % 2;
    de[NTAP-1] = 1;
    measure("R5 ignore", 6, 1'b1);
    clear_skews();
    measure("R5 after ignore", 3, 1'b0);
  endtask

  task automatic t_b2b();  // R6: back-to-back runs start from zero
    clear_skews();
    measure("R6 first", 2, 1'b0);
    measure("R6 second", 1, 1'b0);
    check("R6 second sum", 32'(last_code), 32'(NTAP));
  endtask

  task automatic t_err();  // R7: residue two away from coarse
    clear_skews();
    de[5] = 2;
    de[NTAP-1] = 2;
    ds[NTAP-1] = 2;
    measure("R7 bad tap", 4, 1'b0);
    check("R7 err set", 32'(range_err), 32'd1);
    clear_skews();
    measure("R7 next run", 3, 1'b0);
    check("R7 err sticky", 32'(range_err), 32'd1);
  endtask

  task automatic t_reset_again();  // R8: reset clears result and flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    last_code = '0;
    t_reset();
    clear_skews();
    measure("R8 after reset", 7, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_skew();
    t_wrap();
    t_noise();
    t_b2b();
    t_err();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule